// File: doc/BRIEF.md
# SDRAM Low-Power Entry and Refresh Sequencer

This block sits in the command path of a DRAM controller. It follows two control bits that software writes: a clock-enable bit and a refresh-enable bit. From them it decides when the memory goes into a low-power state and which state that is. It also emits the commands each transition needs, and it keeps a refresh-interval timer running. Periodic refresh is always served as a precharge-all followed by an auto-refresh. A refresh that falls due while the memory sleeps in self-refresh is remembered and served right after the memory wakes.

The low-power state is chosen by the refresh-enable bit as it stands when the clock-enable bit is cleared. If a single write changes both bits, the new value decides. Clearing refresh-enable stops periodic refresh, zeroes the interval timer and drops any refresh that is still owed. The block presents at most one command per cycle on a valid/accept handshake. A command is held until it is accepted, and consecutive commands are kept a fixed number of idle cycles apart. The block also drives the memory's clock-enable pin.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset the clock-enable pin is high and no command is offered. The register bits reset to clock-enable 1 and refresh-enable 0, so no refresh happens until software enables it.
- R2: While refresh-enable is 1, every REF_INTERVAL controller cycles a refresh falls due. Each due refresh is served as PALL then REF. The interval is counted from the write that set refresh-enable.
- R3: cmd_o carries 0=NOP, 1=PALL, 2=REF, 3=SREF_ENTER, 4=PDWN_ENTER, 5=EXIT. A command stays valid and unchanged until cmd_ack accepts it. After an acceptance, at least CMD_GAP cycles pass with no command offered.
- R4: A write that clears clock-enable while refresh-enable is 1 produces PALL then SREF_ENTER. The clock-enable pin goes low once SREF_ENTER is accepted.
- R5: A write that clears clock-enable while refresh-enable is 0 produces PDWN_ENTER alone. The clock-enable pin goes low once it is accepted.
- R6: When one write changes both bits, the low-power choice uses the refresh-enable value written in that same write.
- R7: A write that sets clock-enable while the memory is in a low-power state drives the pin high and produces an EXIT command. No other command is offered while the pin is low.
- R8: If one or more refresh intervals expire during self-refresh, exactly one PALL then REF pair follows the EXIT.
- R9: If self-refresh is entered and left within one refresh interval, only EXIT is issued on wake-up. The next periodic refresh comes when the running timer expires.
- R10: Clearing refresh-enable zeroes the timer, stops periodic refresh and discards an owed refresh. Setting it again restarts the count from zero.
- R11: Setting refresh-enable in the same write that sets clock-enable resumes periodic refresh after the exit.
- R12: A clock-enable-clear write that arrives while a refresh sequence is in progress takes effect only after that sequence's REF is accepted. The low-power entry then follows.
- R13: A write that leaves clock-enable unchanged starts no low-power transition and issues no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_cke | input | 1 | Written clock-enable bit |
| wr_ref_en | input | 1 | Written refresh-enable bit |
| cmd_o | output | 3 | Command code (NOP when not valid) |
| cmd_valid | output | 1 | A command is offered |
| cmd_ack | input | 1 | Command accepted this cycle |
| cke_pin | output | 1 | Memory clock-enable pin |

## Verification
The hardest case to reach is a low-power request that collides with a refresh sequence already in progress. Refresh falls due on an internal timer, so a write would have to land in a window only a few cycles wide. The bench holds cmd_ack low from the start, so the precharge-all of the first due refresh stalls on the port and opens that window indefinitely. The clock-enable-clear write is made inside it, and the acknowledge is then released. The deferred catch-up refresh is reached in a similar way: the bench parks the memory in self-refresh for longer than two intervals and then checks that exactly one precharge and refresh pair follows the exit.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PALL = 3'd1,
    CMD_REF  = 3'd2,
    CMD_SREF = 3'd3,
    CMD_PDWN = 3'd4,
    CMD_EXIT = 3'd5
  } lp_cmd_e;

  typedef enum logic [3:0] {
    ST_ACTIVE,
    ST_RF_PALL,
    ST_RF_REF,
    ST_SR_PALL,
    ST_SR_ENTER,
    ST_PD_ENTER,
    ST_LOWPWR,
    ST_EXIT
  } lp_state_e;

  // true on the last cycle of a refresh interval
  function automatic logic lp_interval_hit(input int unsigned count,
                                           input int unsigned limit);
    return (count + 1) == limit;
  endfunction

  // command that a state presents on the port
  function automatic lp_cmd_e lp_state_cmd(input lp_state_e st);
    case (st)
      ST_RF_PALL, ST_SR_PALL: return CMD_PALL;
      ST_RF_REF:              return CMD_REF;
      ST_SR_ENTER:            return CMD_SREF;
      ST_PD_ENTER:            return CMD_PDWN;
      ST_EXIT:                return CMD_EXIT;
      default:                return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/lp_ref_timer.sv
module lp_ref_timer #(
  parameter int unsigned REF_INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic expire
);
  localparam int CW = $clog2(REF_INTERVAL + 1);

  logic [CW-1:0] count_q;

  assign expire = run && lp_pkg::lp_interval_hit(32'(count_q), REF_INTERVAL);

  always_ff @(posedge clk) begin
    if (!rst_n)                      count_q <= '0;
    else if (clear || !run || expire) count_q <= '0;
    else                             count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/lp_gap_ctr.sv
module lp_gap_ctr #(
  parameter int unsigned CMD_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);
  generate
    if (CMD_GAP == 0) begin : g_nogap
      assign ready = 1'b1;
    end else begin : g_gap
      localparam int GW = $clog2(CMD_GAP + 1);
      logic [GW-1:0] left_q;
      assign ready = (left_q == '0);
      always_ff @(posedge clk) begin
        if (!rst_n)     left_q <= '0;
        else if (load)  left_q <= GW'(CMD_GAP);
        else if (!ready) left_q <= left_q - 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
  import lp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cke_req,
  input  logic    mode_sr,
  input  logic    refresh_owed,
  input  logic    gap_ready,
  input  logic    cmd_ack,
  output lp_cmd_e cmd_o,
  output logic    cmd_valid,
  output logic    cmd_taken,
  output logic    ref_taken,
  output logic    cke_pin
);
  lp_state_e state_q, state_d;
  lp_cmd_e   st_cmd;

  assign st_cmd    = lp_state_cmd(state_q);
  assign cmd_valid = (st_cmd != CMD_NOP) && gap_ready;
  assign cmd_o     = cmd_valid ? st_cmd : CMD_NOP;
  assign cmd_taken = cmd_valid && cmd_ack;
  assign ref_taken = cmd_taken && (state_q == ST_RF_REF);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ACTIVE: begin
        if (refresh_owed)  state_d = ST_RF_PALL;
        else if (!cke_req) state_d = mode_sr ? ST_SR_PALL : ST_PD_ENTER;
      end
      ST_RF_PALL:  if (cmd_taken) state_d = ST_RF_REF;
      ST_RF_REF:   if (cmd_taken) state_d = ST_ACTIVE;
      ST_SR_PALL:  if (cmd_taken) state_d = ST_SR_ENTER;
      ST_SR_ENTER: if (cmd_taken) state_d = ST_LOWPWR;
      ST_PD_ENTER: if (cmd_taken) state_d = ST_LOWPWR;
      ST_LOWPWR:   if (cke_req)   state_d = ST_EXIT;
      ST_EXIT:     if (cmd_taken) state_d = ST_ACTIVE;
      default:                    state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      cke_pin <= 1'b1;
    end else begin
      state_q <= state_d;
      if (cmd_taken && (state_q == ST_SR_ENTER || state_q == ST_PD_ENTER))
        cke_pin <= 1'b0;
      else if (state_q == ST_LOWPWR && cke_req)
        cke_pin <= 1'b1;
    end
  end
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import lp_pkg::*;
#(
  parameter int unsigned REF_INTERVAL = 780,
  parameter int unsigned CMD_GAP      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_cke,
  input  logic       wr_ref_en,
  output logic [2:0] cmd_o,
  output logic       cmd_valid,
  input  logic       cmd_ack,
  output logic       cke_pin
);
  logic    cke_q, ref_en_q, mode_sr_q, owed_q;
  logic    timer_clear, interval_expire;
  logic    gap_ready, cmd_taken, ref_taken;
  logic    cke_drop_wr;
  lp_cmd_e cmd_e;

  assign timer_clear = wr_en && !wr_ref_en;
  assign cke_drop_wr = wr_en && cke_q && !wr_cke;
  assign cmd_o       = cmd_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q     <= 1'b1;
      ref_en_q  <= 1'b0;
      mode_sr_q <= 1'b0;
    end else if (wr_en) begin
      cke_q    <= wr_cke;
      ref_en_q <= wr_ref_en;
      if (cke_drop_wr) mode_sr_q <= wr_ref_en;
    end
  end

  // owed refresh: a refresh-enable clear drops it, an expiry sets it,
  // the accepted REF of a sequence retires it
  always_ff @(posedge clk) begin
    if (!rst_n)               owed_q <= 1'b0;
    else if (timer_clear)     owed_q <= 1'b0;
    else if (interval_expire) owed_q <= 1'b1;
    else if (ref_taken)       owed_q <= 1'b0;
  end

  lp_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ref_en_q),
    .clear  (timer_clear),
    .expire (interval_expire)
  );

  lp_gap_ctr #(.CMD_GAP(CMD_GAP)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_taken),
    .ready (gap_ready)
  );

  lp_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke_req      (cke_q),
    .mode_sr      (mode_sr_q),
    .refresh_owed (owed_q),
    .gap_ready    (gap_ready),
    .cmd_ack      (cmd_ack),
    .cmd_o        (cmd_e),
    .cmd_valid    (cmd_valid),
    .cmd_taken    (cmd_taken),
    .ref_taken    (ref_taken),
    .cke_pin      (cke_pin)
  );
endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk #(
  parameter int unsigned CMD_GAP = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmd_o,
  input logic       cmd_valid,
  input logic       cmd_ack,
  input logic       cke_pin,
  input logic       cmd_taken
);
  localparam int IW = $clog2(CMD_GAP + 2);
  localparam logic [2:0] C_PALL = 3'd1;
  localparam logic [2:0] C_REF  = 3'd2;
  localparam logic [2:0] C_SREF = 3'd3;
  localparam logic [2:0] C_PDWN = 3'd4;

  logic [IW-1:0] idle_q;
  logic [2:0]    last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q <= IW'(CMD_GAP);
      last_q <= 3'd0;
    end else if (cmd_valid && cmd_ack) begin
      idle_q <= '0;
      last_q <= cmd_o;
    end else if (32'(idle_q) < CMD_GAP) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  AST_GAP_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (32'(idle_q) >= CMD_GAP)); // R3

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_o))); // R3

  AST_TAKEN_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_taken |-> (cmd_valid && cmd_ack)); // R3

  AST_REF_AFTER_PALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ack && cmd_o == C_REF) |-> (last_q == C_PALL)); // R2

  AST_SREF_AFTER_PALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ack && cmd_o == C_SREF) |-> (last_q == C_PALL)); // R4

  AST_CKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ack && (cmd_o == C_SREF || cmd_o == C_PDWN)) |=> !cke_pin); // R5

  AST_QUIET_IN_LP: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_pin |-> !cmd_valid); // R7
endmodule

bind sdram_lp_seq lp_seq_chk #(.CMD_GAP(CMD_GAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_o     (cmd_o),
  .cmd_valid (cmd_valid),
  .cmd_ack   (cmd_ack),
  .cke_pin   (cke_pin),
  .cmd_taken (cmd_taken)
);

// File: tb/sim_sdram_lp_seq.sv
`timescale 1ns/100ps
module sim_sdram_lp_seq;
  localparam int unsigned RI  = 64;
  localparam int unsigned GAP = 3;
  localparam logic [2:0] C_PALL = 3'd1, C_REF = 3'd2, C_SREF = 3'd3,
                         C_PDWN = 3'd4, C_EXIT = 3'd5;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_cke = 1, wr_ref_en = 0, cmd_ack = 1;
  logic [2:0] cmd_o;
  logic cmd_valid, cke_pin;

  int vectors = 0, miscompares = 0;
  int cyc = 0, last_acc = -1000;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  sdram_lp_seq #(.REF_INTERVAL(RI), .CMD_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cke(wr_cke),
    .wr_ref_en(wr_ref_en), .cmd_o(cmd_o), .cmd_valid(cmd_valid),
    .cmd_ack(cmd_ack), .cke_pin(cke_pin));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_cmd(input logic [2:0] c, input string req);
    exp_q.push_back(c);
    tag_q.push_back(req);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic cke, input logic ren);
    @(posedge clk); #1;
    wr_en = 1; wr_cke = cke; wr_ref_en = ren;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; wr_en = 0; cmd_ack = 1;
    ticks(3);
    rst_n = 1;
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic check_drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // monitor: pops the scoreboard on every accepted command
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cmd_valid && cmd_ack) begin
      if (last_acc >= 0)
        check((cyc - last_acc) >= int'(GAP) + 1, "R3 gap", cyc - last_acc, GAP + 1);
      last_acc = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected command", int'(cmd_o), 0);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cmd_o == e, t, int'(cmd_o), int'(e));
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    ticks(2);
    check(cke_pin == 1'b1, "R1 cke_pin", cke_pin, 1);
    check(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
    ticks(RI + 10);
    check_drained("R1 no refresh while disabled");

    // R2 periodic refresh; R13 unchanged-CKE write
    reg_write(1, 1);
    ticks(50);
    check_drained("R2 nothing before interval");
    expect_cmd(C_PALL, "R2"); expect_cmd(C_REF, "R2");
    ticks(30);
    check_drained("R2 first refresh");
    reg_write(1, 1);
    expect_cmd(C_PALL, "R2"); expect_cmd(C_REF, "R2");
    ticks(RI);
    check_drained("R13 second refresh on schedule only");

    // R9: self-refresh within one interval
    do_reset();
    reg_write(1, 1);
    ticks(10);
    expect_cmd(C_PALL, "R4"); expect_cmd(C_SREF, "R4");
    reg_write(0, 1);
    ticks(15);
    check(cke_pin == 1'b0, "R4 cke_pin low", cke_pin, 0);
    check_drained("R4 entry");
    expect_cmd(C_EXIT, "R7");
    reg_write(1, 1);
    ticks(1);
    check(cke_pin == 1'b1, "R7 cke_pin high", cke_pin, 1);
    ticks(20);
    check_drained("R9 only exit");
    expect_cmd(C_PALL, "R9"); expect_cmd(C_REF, "R9");
    ticks(30);
    check_drained("R9 periodic on schedule");

    // R8: catch-up after long self-refresh
    do_reset();
    reg_write(1, 1);
    ticks(5);
    expect_cmd(C_PALL, "R4"); expect_cmd(C_SREF, "R4");
    reg_write(0, 1);
    ticks(150);
    check_drained("R7 quiet in self-refresh");
    expect_cmd(C_EXIT, "R7"); expect_cmd(C_PALL, "R8"); expect_cmd(C_REF, "R8");
    reg_write(1, 1);
    ticks(20);
    check_drained("R8 one catch-up pair");

    // R6/R5 power-down via same-write REF_EN clear; R10; R11
    do_reset();
    reg_write(1, 1);
    ticks(5);
    expect_cmd(C_PDWN, "R6");
    reg_write(0, 0);
    ticks(10);
    check(cke_pin == 1'b0, "R5 cke_pin low", cke_pin, 0);
    check_drained("R5 pdwn only");
    ticks(150);
    check_drained("R10 no refresh with ref disabled");
    expect_cmd(C_EXIT, "R11");
    reg_write(1, 1);
    ticks(50);
    check_drained("R11 exit only before interval");
    expect_cmd(C_PALL, "R11"); expect_cmd(C_REF, "R11");
    ticks(30);
    check_drained("R11 periodic resumed");

    // R10: timer restart, R13: CKE-unchanged writes
    do_reset();
    reg_write(1, 1);
    ticks(40);
    reg_write(1, 0);
    ticks(100);
    check_drained("R10 cleared timer");
    check(cke_pin == 1'b1, "R13 cke_pin", cke_pin, 1);
    reg_write(1, 1);
    ticks(55);
    check_drained("R10 restart from zero");
    expect_cmd(C_PALL, "R10"); expect_cmd(C_REF, "R10");
    ticks(30);
    check_drained("R10 refresh after restart");

    // R12: entry request during a stalled refresh sequence
    do_reset();
    cmd_ack = 0;
    reg_write(1, 1);
    ticks(70);
    check(cmd_valid == 1'b1, "R3 held valid", cmd_valid, 1);
    check(cmd_o == C_PALL, "R3 held code", cmd_o, C_PALL);
    expect_cmd(C_PALL, "R12"); expect_cmd(C_REF, "R12");
    expect_cmd(C_PALL, "R12"); expect_cmd(C_SREF, "R12");
    reg_write(0, 1);
    ticks(3);
    cmd_ack = 1;
    ticks(30);
    check_drained("R12 refresh before entry");
    check(cke_pin == 1'b0, "R12 cke_pin low", cke_pin, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule